// File: doc/BRIEF.md
# Shadow RAM Segment Access Decoder

This block routes each memory cycle that falls in the upper legacy window, 0C0000h to 0FFFFFh. It looks at the cycle's address, its direction (read or write) and three shadow control bytes. From these it picks one of three outcomes: the cycle is served by on-board DRAM, it is passed to the external ROM/expansion bus, or it is a write that is silently discarded. The control bytes come from the register file that sits next to this block. Each 16 KB option segment has its own enable bit. An area bit gates each segment group. Write locks apply per area, and a copy mode sends reads to the bus and writes to DRAM, so option ROM contents can be copied into shadow memory.

Cycles above 1 MB or below 0C0000h always go to DRAM. The 64 KB system BIOS segment at F0000h has a single mode bit. This bit chooses between ROM-read/DRAM-write and DRAM-read/write-discard. Each decision is registered, so the outcome appears one clock after the request. A build option can remove the output register.

Top module: `shadow_map_decoder`

## Requirements
- R1: For addresses F0000h-FFFFFh with ctl_area bit 7 set, a read selects the bus and a write selects DRAM.
- R2: For addresses F0000h-FFFFFh with ctl_area bit 7 clear, a read selects DRAM and a write asserts write_drop.
- R3: Segment i (i = 0..7) of the D0000h-EFFFFh range starts at D0000h + i*4000h. It is enabled only when ctl_seg_de bit i is set and its area bit is also set. The area bit is ctl_area bit 5 for segments at E0000h and above, and ctl_area bit 6 for segments below E0000h.
- R4: An enabled D/E segment with copy mode off reads from DRAM. A write goes to DRAM unless its area lock is set, in which case write_drop is asserted. The lock is ctl_area bit 4 for the D0000h area and bit 3 for the E0000h area.
- R5: Segment i (i = 0..3) of C0000h-CFFFFh starts at C0000h + i*4000h. It is enabled by ctl_seg_c bit i together with ctl_seg_c bit 4. With copy mode off it reads from DRAM. Its writes go to DRAM, or are dropped when ctl_seg_c bit 5 is set.
- R6: When ctl_seg_c bit 6 (copy mode) is set, every enabled segment in C0000h-EFFFFh sends reads to the bus and writes to DRAM, whatever the lock bits say. Copy mode has no effect on F0000h-FFFFFh.
- R7: A segment in C0000h-EFFFFh that is not enabled sends both reads and writes to the bus.
- R8: When out_valid is high, exactly one of dram_sel, bus_sel and write_drop is high. When out_valid is low, all three are low.
- R9: Addresses below C0000h or at or above 100000h select DRAM for reads and writes, whatever the control bytes hold.
- R10: With the output register built in (the default), the outputs reflect the request presented one clock earlier. Reset clears out_valid and all three selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A memory cycle is presented this clock |
| req_addr | input | AW | Physical byte address of the cycle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| ctl_area | input | 8 | Area control byte: BIOS mode, area enables, area write locks |
| ctl_seg_de | input | 8 | Per-segment enables for D0000h-EFFFFh |
| ctl_seg_c | input | 8 | C-range segment enables, C-range enable, C-range lock, copy mode |
| out_valid | output | 1 | A routing decision is presented |
| dram_sel | output | 1 | Cycle goes to on-board DRAM |
| bus_sel | output | 1 | Cycle goes to the external ROM/expansion bus |
| write_drop | output | 1 | Write cycle is discarded |

## Verification
The embedded properties check on every clock that the three selects form a clean one-of-three code while a decision is valid and stay at zero otherwise. They also check that a discard only ever follows a write, that out-of-window addresses land in DRAM, that copy-mode reads never land in DRAM, and that ROM-mode BIOS reads reach the bus. The finer per-segment mapping needs the bench's sweeps of addresses against many control byte patterns, compared with an arithmetic model. That mapping covers which enable bit and which area bit gate which 16 KB segment, which lock applies to which area, and copy mode overriding a lock.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

   // Routing outcome of one memory cycle
   typedef enum logic [1:0] {
      RT_DRAM = 2'd0,
      RT_BUS  = 2'd1,
      RT_DROP = 2'd2
   } route_t;

   // Address classes inside and around the legacy window
   typedef enum logic [1:0] {
      RG_OTHER = 2'd0,
      RG_C     = 2'd1,
      RG_DE    = 2'd2,
      RG_BIOS  = 2'd3
   } region_t;

   localparam int LEGACY_W   = 20;  // 1 MB boundary
   localparam int SEG_SHIFT  = 14;  // 16 KB segments
   localparam int NSEG_DE    = 8;
   localparam int NSEG_C     = 4;
   localparam int SEG_IDX_W  = $clog2(NSEG_DE);

   // Bit positions decoded from the neighbouring register file
   localparam int B_BIOS_ROM  = 7;
   localparam int B_D_AREA_EN = 6;
   localparam int B_E_AREA_EN = 5;
   localparam int B_D_LOCK    = 4;
   localparam int B_E_LOCK    = 3;
   localparam int B_C_EN      = 4;
   localparam int B_C_LOCK    = 5;
   localparam int B_COPY      = 6;

endpackage

// File: rtl/shadow_region_classify.sv
module shadow_region_classify
   import shadow_pkg::*;
#(
   parameter int AW = 24
) (
   input  logic [AW-1:0]        addr,
   output region_t              region,
   output logic [SEG_IDX_W-1:0] seg_idx
);

   localparam int HI_W = AW - LEGACY_W;

   logic       below_1m;
   logic [3:0] blk64k;

   generate
      if (HI_W > 0) begin : g_hi
         assign below_1m = (addr[AW-1:LEGACY_W] == '0);
      end else begin : g_nohi
         assign below_1m = 1'b1;
      end
   endgenerate

   assign blk64k = addr[LEGACY_W-1:LEGACY_W-4];

   always_comb begin
      region  = RG_OTHER;
      seg_idx = {1'b0, addr[SEG_SHIFT+1:SEG_SHIFT]};
      if (below_1m) begin
         unique case (blk64k)
            4'hC: region = RG_C;
            4'hD: region = RG_DE;
            4'hE: begin
               region  = RG_DE;
               seg_idx = {1'b1, addr[SEG_SHIFT+1:SEG_SHIFT]};
            end
            4'hF: region = RG_BIOS;
            default: region = RG_OTHER;
         endcase
      end
   end

endmodule

// File: rtl/shadow_seg_policy.sv
module shadow_seg_policy
   import shadow_pkg::*;
(
   input  logic   seg_on,
   input  logic   wr_lock,
   input  logic   copy_mode,
   input  logic   is_write,
   output route_t route
);

   always_comb begin
      if (!seg_on)
         route = RT_BUS;
      else if (copy_mode)
         route = is_write ? RT_DRAM : RT_BUS;
      else if (is_write)
         route = wr_lock ? RT_DROP : RT_DRAM;
      else
         route = RT_DRAM;
   end

endmodule

// File: rtl/shadow_route_stage.sv
module shadow_route_stage
   import shadow_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   in_valid,
   input  route_t in_route,
   output logic   out_valid,
   output logic   dram_sel,
   output logic   bus_sel,
   output logic   write_drop
);

   logic [2:0] sel_d;

   always_comb begin
      sel_d = 3'b000;
      if (in_valid) begin
         unique case (in_route)
            RT_DRAM: sel_d = 3'b001;
            RT_BUS:  sel_d = 3'b010;
            RT_DROP: sel_d = 3'b100;
            default: sel_d = 3'b001;
         endcase
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         logic       vld_q;
         logic [2:0] sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               sel_q <= 3'b000;
            end else begin
               vld_q <= in_valid;
               sel_q <= sel_d;
            end
         end
         assign out_valid = vld_q;
         assign {write_drop, bus_sel, dram_sel} = sel_q;
      end else begin : g_comb
         assign out_valid = in_valid;
         assign {write_drop, bus_sel, dram_sel} = sel_d;
      end
   endgenerate

endmodule

// File: rtl/shadow_map_decoder.sv
module shadow_map_decoder
   import shadow_pkg::*;
#(
   parameter int AW      = 24,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   input  logic          req_write,
   input  logic [7:0]    ctl_area,
   input  logic [7:0]    ctl_seg_de,
   input  logic [7:0]    ctl_seg_c,
   output logic          out_valid,
   output logic          dram_sel,
   output logic          bus_sel,
   output logic          write_drop
);

   generate
      if (AW < LEGACY_W || AW > 64) begin : g_bad_aw
         initial $fatal(1, "shadow_map_decoder: AW must be within 20..64");
      end
   endgenerate

   region_t              region;
   logic [SEG_IDX_W-1:0] seg_idx;
   route_t               de_route [NSEG_DE];
   route_t               c_route  [NSEG_C];
   route_t               bios_route;
   route_t               sel_route;
   logic                 copy_mode;

   assign copy_mode = ctl_seg_c[B_COPY];

   shadow_region_classify #(.AW(AW)) u_class (
      .addr    (req_addr),
      .region  (region),
      .seg_idx (seg_idx)
   );

   // D0000h-EFFFFh: lower half uses the D area bits, upper half the E area bits
   generate
      for (genvar i = 0; i < NSEG_DE; i++) begin : g_de
         localparam bit IS_E = (i >= NSEG_DE / 2);
         logic area_on, lock;
         assign area_on = IS_E ? ctl_area[B_E_AREA_EN] : ctl_area[B_D_AREA_EN];
         assign lock    = IS_E ? ctl_area[B_E_LOCK]    : ctl_area[B_D_LOCK];
         shadow_seg_policy u_pol (
            .seg_on    (area_on & ctl_seg_de[i]),
            .wr_lock   (lock),
            .copy_mode (copy_mode),
            .is_write  (req_write),
            .route     (de_route[i])
         );
      end

      for (genvar j = 0; j < NSEG_C; j++) begin : g_c
         shadow_seg_policy u_pol (
            .seg_on    (ctl_seg_c[B_C_EN] & ctl_seg_c[j]),
            .wr_lock   (ctl_seg_c[B_C_LOCK]),
            .copy_mode (copy_mode),
            .is_write  (req_write),
            .route     (c_route[j])
         );
      end
   endgenerate

   // System BIOS segment: one mode bit, no copy mode
   always_comb begin
      if (ctl_area[B_BIOS_ROM])
         bios_route = req_write ? RT_DRAM : RT_BUS;
      else
         bios_route = req_write ? RT_DROP : RT_DRAM;
   end

   always_comb begin
      unique case (region)
         RG_BIOS: sel_route = bios_route;
         RG_DE:   sel_route = de_route[seg_idx];
         RG_C:    sel_route = c_route[seg_idx[1:0]];
         default: sel_route = RT_DRAM;
      endcase
   end

   shadow_route_stage #(.REG_OUT(REG_OUT)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (req_valid),
      .in_route   (sel_route),
      .out_valid  (out_valid),
      .dram_sel   (dram_sel),
      .bus_sel    (bus_sel),
      .write_drop (write_drop)
   );

   // Properties observed at the ports
   logic [63:0] addr_ext;
   assign addr_ext = 64'(req_addr);

   generate
      if (REG_OUT) begin : g_chk
         a_r8_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($countones({dram_sel, bus_sel, write_drop}) == 1));

         a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> ({dram_sel, bus_sel, write_drop} == 3'b000));

         a_r2_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_write) |=> !write_drop);

         a_r9_outside_dram: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && (addr_ext < 64'h0C_0000 || addr_ext >= 64'h10_0000)) |=> dram_sel);

         a_r6_copy_read_off_dram: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_write && ctl_seg_c[B_COPY] &&
             addr_ext >= 64'h0C_0000 && addr_ext < 64'h0F_0000) |=> !dram_sel);

         a_r1_rom_read_bus: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_write && ctl_area[B_BIOS_ROM] &&
             addr_ext >= 64'h0F_0000 && addr_ext < 64'h10_0000) |=> bus_sel);
      end
   endgenerate

endmodule

// File: tb/sim_shadow_map_decoder.sv
module sim_shadow_map_decoder;

   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic [7:0]    ctl_area = 8'h00;
   logic [7:0]    ctl_seg_de = 8'h00;
   logic [7:0]    ctl_seg_c = 8'h00;
   logic          out_valid, dram_sel, bus_sel, write_drop;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   shadow_map_decoder #(.AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .ctl_area(ctl_area), .ctl_seg_de(ctl_seg_de),
      .ctl_seg_c(ctl_seg_c), .out_valid(out_valid), .dram_sel(dram_sel),
      .bus_sel(bus_sel), .write_drop(write_drop)
   );

   // Expected selects as {drop, bus, dram}
   function automatic logic [2:0] model(input logic [AW-1:0] ad, input logic wr,
                                         input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] c, output string tag);
      longint x = longint'(ad);
      int idx;
      bit en, lk, is_de;
      if (x < 'hC0000 || x >= 'h100000) begin
         tag = "R9";
         return 3'b001;
      end
      if (x >= 'hF0000) begin
         tag = a[7] ? "R1" : "R2";
         if (a[7]) return wr ? 3'b001 : 3'b010;
         return wr ? 3'b100 : 3'b001;
      end
      is_de = (x >= 'hD0000);
      if (is_de) begin
         idx = int'((x - 'hD0000) / 'h4000);
         en  = b[idx] && ((x >= 'hE0000) ? a[5] : a[6]);
         lk  = (x >= 'hE0000) ? a[3] : a[4];
      end else begin
         idx = int'((x - 'hC0000) / 'h4000);
         en  = c[idx] && c[4];
         lk  = c[5];
      end
      if (!en) begin
         tag = is_de ? "R7 R3" : "R7";
         return 3'b010;
      end
      if (c[6]) begin
         tag = "R6";
         return wr ? 3'b001 : 3'b010;
      end
      tag = is_de ? "R3 R4" : "R5";
      if (wr) return lk ? 3'b100 : 3'b001;
      return 3'b001;
   endfunction

   task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: got {drop,bus,dram}=%b expected %b (addr=%h wr=%0b a=%h b=%h c=%h)",
                  tag, act, exp, req_addr, req_write, ctl_area, ctl_seg_de, ctl_seg_c);
      end
   endtask

   // Called at a negedge; samples one clock later at the next negedge
   task automatic run(input logic [AW-1:0] ad, input logic wr);
      string tag;
      logic [2:0] e;
      req_valid = 1'b1;
      req_addr  = ad;
      req_write = wr;
      e = model(ad, wr, ctl_area, ctl_seg_de, ctl_seg_c, tag);
      @(negedge clk);
      check(tag, {write_drop, bus_sel, dram_sel}, e);
      check("R8 valid", {2'b00, out_valid}, 3'b001);
      if ($countones({write_drop, bus_sel, dram_sel}) != 1)
         check("R8 one-hot", {write_drop, bus_sel, dram_sel}, e);
   endtask

   task automatic sweep(input int salt);
      for (int s = 0; s < 16; s++) begin
         logic [AW-1:0] ad;
         ad = AW'(32'hC0000 + s * 32'h4000 + ((salt * 32'h135 + s * 32'h3F1) & 32'h3FFF));
         run(ad, 1'b0);
         run(ad, 1'b1);
      end
      run(AW'(32'h0BFFFF), 1'b0);
      run(AW'(32'h100000), 1'b1);
      run(AW'(32'h000000), 1'b1);
      run(AW'(32'h1F0000 + salt), 1'b0);
      run(AW'(32'hFFFFFF), 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 reset", {write_drop, bus_sel, dram_sel}, 3'b000);
      check("R10 reset valid", {2'b00, out_valid}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 and R7 with all control bytes clear
      sweep(0);
      // Everything set: copy on, locks on (R6 overrides locks)
      ctl_area = 8'hFF; ctl_seg_de = 8'hFF; ctl_seg_c = 8'hFF;
      sweep(1);
      // R4: locks without copy, both areas enabled
      ctl_area = 8'hF8; ctl_seg_de = 8'hA5; ctl_seg_c = 8'h3F;
      sweep(2);
      // R3: one area bit only, checks area gating per half
      ctl_area = 8'h20; ctl_seg_de = 8'hFF; ctl_seg_c = 8'h10;
      sweep(3);
      ctl_area = 8'h40;
      sweep(4);
      // Walking single segment enables (R3, R5)
      for (int i = 0; i < 8; i++) begin
         ctl_area = 8'h60; ctl_seg_de = 8'(1 << i); ctl_seg_c = 8'h10 | 8'(1 << (i % 4));
         sweep(5 + i);
      end
      // Deterministic spread of control patterns
      for (int k = 0; k < 64; k++) begin
         ctl_area   = 8'((k * 37 + 11) & 255);
         ctl_seg_de = 8'((k * 91 + 5) & 255);
         ctl_seg_c  = 8'((k * 53 + 29) & 255);
         sweep(20 + k);
      end

      // R8 and R10: no request gives all-low outputs one clock later
      req_valid = 1'b0;
      @(negedge clk);
      check("R8 idle", {write_drop, bus_sel, dram_sel}, 3'b000);
      check("R10 idle valid", {2'b00, out_valid}, 3'b000);

      // R10: reset in mid-stream clears outputs
      run(AW'(32'hF1234), 1'b0);
      req_valid = 1'b1;
      rst_n = 1'b0;
      #1;
      check("R10 async reset", {write_drop, bus_sel, dram_sel}, 3'b000);
      @(negedge clk);
      rst_n = 1'b1;
      req_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule